// File: doc/BRIEF.md
# Result Routing and Method Send Unit

This unit sits behind the execution core of a small command-processing engine. Each cycle the core may offer a computed 32-bit result, a 3-bit destination register number and a 3-bit routing code. The routing code is taken by the core from bits [6:4] of the instruction word. The unit decides, from the routing code, what to do with the result. It can write the result to the register file, or take the next word from the parameter queue and write that word instead. It can load the method address register from the result. It can also emit a send transaction, which is a pair of method address and data, toward a downstream engine.

The method address register has two parts: a 12-bit target address and a 6-bit step. Every send goes to the current target address, and the target then moves forward by the step. This lets a run of sends fill consecutive or strided method slots without reloading the register.

Back-pressure works in both directions. The core is held with `resReady` low while a required parameter has not arrived. It is also held while a send is needed and the single-entry send output is still occupied.

Top module: `result_router`

## Requirements
- R1: Routing codes 1, 2, 4 and 7 write the result to the destination register. On such a write, `regWe` is high for one cycle together with `regAddr` equal to `resDst` and `regData` equal to `resData`. Code 6 also writes the result to the destination register.
- R2: Routing codes 0, 3 and 5 consume exactly one parameter word and write that word to the destination register. Code 6 consumes one parameter word and does not write it to a register. Parameter words are used in arrival order. `parmReady` is high on an accepted result only for codes 0, 3, 5 and 6.
- R3: When `resDst` is 0, no register write is issued (`regWe` stays low), and any other effects of the routing code still take place.
- R4: Routing codes 2, 5, 6 and 7 load the method address register. The target address is loaded from `resData[11:0]` and the step from `resData[17:12]`.
- R5: Routing codes 3, 4, 6 and 7 issue one send. For codes 3, 4 and 7 the send data is the result; for code 6 it is the fetched parameter word. Codes 6 and 7 send to the address they have just loaded. Codes 3 and 4 send to the current target address.
- R6: After each send, the target address advances by the step, modulo 4096.
- R7: An accepted result whose code needs a parameter is not accepted while `parmValid` is low. In that state `resReady` is low and `regWe` is low.
- R8: While `sendValid` is high and `sendReady` is low, `sendAddr` and `sendData` hold steady. A result that needs a send is then not accepted. A result that needs no send is still accepted.
- R9: After reset, `sendValid` is low, the target address is 0 and the step is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resValid | input | 1 | Core offers a result |
| resReady | output | 1 | Unit accepts the offered result this cycle |
| resOp | input | 3 | Routing code |
| resDst | input | 3 | Destination register number |
| resData | input | 32 | Computed result |
| parmValid | input | 1 | Parameter queue has a word |
| parmReady | output | 1 | Parameter word consumed this cycle |
| parmData | input | 32 | Head parameter word |
| regWe | output | 1 | Register write strobe |
| regAddr | output | 3 | Register write index |
| regData | output | 32 | Register write value |
| sendValid | output | 1 | Send transaction pending |
| sendReady | input | 1 | Downstream accepts the send |
| sendAddr | output | 12 | Method address of the send |
| sendData | output | 32 | Data of the send |

## Verification
The bench targets the target-address wrap from 0xFFE with a step of 3. A design that lost the modulo or advanced by the wrong amount would send to a wrong slot. It also targets code 6, which sends the fetched word but writes the result. A design that swapped those two values would show wrong register and send data. Empty-queue stalls and a full send slot are forced to check that no result slips through early and that a write with no send still proceeds. Writes to register 0 are checked to leave `regWe` low while the set-method and send effects still happen.

// File: rtl/result_router_pkg.sv
package result_router_pkg;

  typedef enum logic [2:0] {
    OP_FETCH       = 3'd0,
    OP_MOVE        = 3'd1,
    OP_MOVE_SET    = 3'd2,
    OP_FETCH_SEND  = 3'd3,
    OP_MOVE_SEND   = 3'd4,
    OP_FETCH_SET   = 3'd5,
    OP_SET_PSEND   = 3'd6,
    OP_SET_SEND    = 3'd7
  } resultOp_e;

  // strobes from control to datapath, valid only on an accepted result
  typedef struct packed {
    logic writeParm;  // register value comes from the parameter word
    logic setMethod;  // load target address and step from the result
    logic loadSend;   // fill the send output slot
    logic sendParm;   // send data comes from the parameter word
  } routeCtl_t;

endpackage

// File: rtl/result_router_ctrl.sv
module result_router_ctrl
  import result_router_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resValid,
  input  logic [2:0]       resOp,
  input  logic [REG_W-1:0] resDst,
  input  logic             parmValid,
  input  logic             sendValid,
  input  logic             sendReady,
  output logic             resReady,
  output logic             parmReady,
  output logic             regWe,
  output routeCtl_t        ctl
);

  resultOp_e op;
  logic writeParm, sendParm, setMethod, doSend, needFetch;
  logic parmOk, slotOk, fire;

  assign op = resultOp_e'(resOp);

  always_comb begin
    writeParm = 1'b0;
    sendParm  = 1'b0;
    setMethod = 1'b0;
    doSend    = 1'b0;
    unique case (op)
      OP_FETCH:      writeParm = 1'b1;
      OP_MOVE:       ;
      OP_MOVE_SET:   setMethod = 1'b1;
      OP_FETCH_SEND: begin writeParm = 1'b1; doSend = 1'b1; end
      OP_MOVE_SEND:  doSend = 1'b1;
      OP_FETCH_SET:  begin writeParm = 1'b1; setMethod = 1'b1; end
      OP_SET_PSEND:  begin sendParm = 1'b1; setMethod = 1'b1; doSend = 1'b1; end
      OP_SET_SEND:   begin setMethod = 1'b1; doSend = 1'b1; end
      default:       ;
    endcase
  end

  assign needFetch = writeParm | sendParm;
  assign parmOk    = !needFetch || parmValid;
  assign slotOk    = !doSend || !sendValid || sendReady;
  assign resReady  = parmOk && slotOk;
  assign fire      = resValid && resReady;
  assign parmReady = fire && needFetch;
  assign regWe     = fire && (resDst != '0);

  assign ctl.writeParm = writeParm;
  assign ctl.sendParm  = sendParm;
  assign ctl.setMethod = fire && setMethod;
  assign ctl.loadSend  = fire && doSend;

  assert_fetch_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && needFetch && !parmValid) |-> (!resReady && !regWe));

endmodule

// File: rtl/result_router_dp.sv
module result_router_dp
  import result_router_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int INC_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  routeCtl_t         ctl,
  input  logic [DATA_W-1:0] resData,
  input  logic [DATA_W-1:0] parmData,
  input  logic              sendReady,
  output logic [DATA_W-1:0] regData,
  output logic              sendValid,
  output logic [ADDR_W-1:0] sendAddr,
  output logic [DATA_W-1:0] sendData
);

  localparam int INC_LSB = ADDR_W;
  localparam int INC_MSB = ADDR_W + INC_W - 1;

  logic [ADDR_W-1:0] methodAddr, baseAddr;
  logic [INC_W-1:0]  methodInc, baseInc;

  assign regData  = ctl.writeParm ? parmData : resData;
  assign baseAddr = ctl.setMethod ? resData[ADDR_W-1:0] : methodAddr;
  assign baseInc  = ctl.setMethod ? resData[INC_MSB:INC_LSB] : methodInc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      methodAddr <= '0;
      methodInc  <= '0;
    end else if (ctl.setMethod || ctl.loadSend) begin
      methodInc  <= baseInc;
      methodAddr <= ctl.loadSend ? baseAddr + ADDR_W'(baseInc) : baseAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sendValid <= 1'b0;
      sendAddr  <= '0;
      sendData  <= '0;
    end else if (ctl.loadSend) begin
      sendValid <= 1'b1;
      sendAddr  <= baseAddr;
      sendData  <= ctl.sendParm ? parmData : resData;
    end else if (sendReady) begin
      sendValid <= 1'b0;
    end
  end

  assert_send_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sendValid && !sendReady) |=> (sendValid && $stable(sendAddr) && $stable(sendData)));

  assert_slot_free_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadSend |-> (!sendValid || sendReady));

endmodule

// File: rtl/result_router.sv
module result_router
  import result_router_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int INC_W  = 6,
  parameter int REG_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValid,
  output logic              resReady,
  input  logic [2:0]        resOp,
  input  logic [REG_W-1:0]  resDst,
  input  logic [DATA_W-1:0] resData,
  input  logic              parmValid,
  output logic              parmReady,
  input  logic [DATA_W-1:0] parmData,
  output logic              regWe,
  output logic [REG_W-1:0]  regAddr,
  output logic [DATA_W-1:0] regData,
  output logic              sendValid,
  input  logic              sendReady,
  output logic [ADDR_W-1:0] sendAddr,
  output logic [DATA_W-1:0] sendData
);

  routeCtl_t ctl;

  assign regAddr = resDst;

  result_router_ctrl #(.REG_W(REG_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resOp(resOp), .resDst(resDst),
    .parmValid(parmValid), .sendValid(sendValid), .sendReady(sendReady),
    .resReady(resReady), .parmReady(parmReady), .regWe(regWe), .ctl(ctl)
  );

  result_router_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INC_W(INC_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .resData(resData), .parmData(parmData),
    .sendReady(sendReady), .regData(regData), .sendValid(sendValid),
    .sendAddr(sendAddr), .sendData(sendData)
  );

  assert_send_issue_R5: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resReady && (resOp inside {3'd3, 3'd4, 3'd6, 3'd7})) |=> sendValid);

  assert_parm_with_result_R2: assert property (@(posedge clk) disable iff (!rstN)
    (parmValid && parmReady) |-> (resValid && resReady));

  assert_reg0_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resDst == '0) |-> !regWe);

endmodule

// File: tb/test_result_router.sv
module test_result_router;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resValid = 1'b0;
  logic        resReady;
  logic [2:0]  resOp = '0;
  logic [2:0]  resDst = '0;
  logic [31:0] resData = '0;
  logic        parmValid = 1'b0;
  logic        parmReady;
  logic [31:0] parmData;
  logic        regWe;
  logic [2:0]  regAddr;
  logic [31:0] regData;
  logic        sendValid;
  logic        sendReady = 1'b0;
  logic [11:0] sendAddr;
  logic [31:0] sendData;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  result_router i_result_router (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resReady(resReady), .resOp(resOp),
    .resDst(resDst), .resData(resData), .parmValid(parmValid), .parmReady(parmReady),
    .parmData(parmData), .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .sendValid(sendValid), .sendReady(sendReady), .sendAddr(sendAddr), .sendData(sendData)
  );

  // parameter queue source
  logic [31:0] pList [0:1023];
  int pIdx = 0;
  int pN = 1024;
  bit holdParm = 0;
  assign parmData = pList[pIdx];

  // send sink control
  bit sendHold = 0;
  bit sendForce = 0;

  // bench model
  logic [11:0] mAddr = '0;
  logic [5:0]  mInc = '0;
  int pUsed = 0;
  logic [11:0] expA [0:2047];
  logic [31:0] expD [0:2047];
  int head = 0;
  int tail = 0;

  function automatic bit usesFetch(input logic [2:0] op);
    return op == 3'd0 || op == 3'd3 || op == 3'd5 || op == 3'd6;
  endfunction
  function automatic bit usesSend(input logic [2:0] op);
    return op == 3'd3 || op == 3'd4 || op == 3'd6 || op == 3'd7;
  endfunction
  function automatic bit usesSet(input logic [2:0] op);
    return op == 3'd2 || op == 3'd5 || op == 3'd6 || op == 3'd7;
  endfunction
  function automatic bit writesParm(input logic [2:0] op);
    return op == 3'd0 || op == 3'd3 || op == 3'd5;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: sample away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (sendValid && sendReady) begin
        if (head == tail) check(0, "R5 unexpected send", {20'd0, sendAddr, sendData}, 64'd0);
        else begin
          check(sendAddr == expA[head], "R4 R6 send address", 64'(sendAddr), 64'(expA[head]));
          check(sendData == expD[head], "R5 send data", 64'(sendData), 64'(expD[head]));
          head++;
        end
      end
      if (resValid) begin
        bit expReady;
        expReady = (!usesFetch(resOp) || parmValid) &&
                   (!usesSend(resOp) || !sendValid || sendReady);
        check(resReady == expReady, "R7 R8 accept", 64'(resReady), 64'(expReady));
        if (!expReady) check(!regWe, "R7 no write on stall", 64'(regWe), 64'd0);
        if (resReady) begin
          logic [31:0] wv;
          check(parmReady == usesFetch(resOp), "R2 parm consume", 64'(parmReady), 64'(usesFetch(resOp)));
          wv = writesParm(resOp) ? pList[pUsed] : resData;
          if (resDst == 3'd0)
            check(!regWe, "R3 reg0 write suppressed", 64'(regWe), 64'd0);
          else
            check(regWe && regAddr == resDst && regData == wv, "R1 R2 register write",
                  {31'd0, regWe, regData}, {32'd1, wv});
          if (usesSet(resOp)) begin
            mAddr = resData[11:0];
            mInc  = resData[17:12];
          end
          if (usesSend(resOp)) begin
            expA[tail] = mAddr;
            expD[tail] = (resOp == 3'd6) ? pList[pUsed] : resData;
            tail++;
            mAddr = mAddr + 12'(mInc);
          end
          if (usesFetch(resOp)) pUsed++;
        end
      end else begin
        check(!parmReady && !regWe, "R2 idle", {62'd0, parmReady, regWe}, 64'd0);
      end
    end
  end

  // parameter source driver
  initial begin
    bit take;
    forever begin
      @(negedge clk);
      take = parmValid && parmReady;
      @(posedge clk);
      #1;
      if (take) pIdx++;
      parmValid = !holdParm && (pIdx < pN - 1) && ($urandom % 4 != 0);
    end
  end

  // send sink driver
  initial begin
    forever begin
      @(posedge clk);
      #1;
      sendReady = sendForce ? 1'b1 : (sendHold ? 1'b0 : ($urandom % 3 != 0));
    end
  end

  task automatic issue(input logic [2:0] op, input logic [2:0] dst, input logic [31:0] d);
    resValid = 1'b1;
    resOp = op;
    resDst = dst;
    resData = d;
    forever begin
      @(negedge clk);
      if (resReady) break;
    end
    @(posedge clk);
    #1;
    resValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 1024; i++) pList[i] = $urandom;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!sendValid, "R9 reset send idle", 64'(sendValid), 64'd0);
    @(posedge clk);
    #1;

    // R9: first send goes to target 0 with step 0
    issue(3'd4, 3'd1, 32'hA5A5_0001);
    issue(3'd4, 3'd2, 32'hA5A5_0002);
    // R4 R6: wrap from 0xFFE with step 3, R3 on register 0
    issue(3'd2, 3'd2, {14'd0, 6'd3, 12'hFFE});
    issue(3'd4, 3'd0, 32'h1111_2222);
    issue(3'd4, 3'd5, 32'h3333_4444);
    // code 6 sends the fetched word, writes the result
    issue(3'd6, 3'd6, {14'd0, 6'd1, 12'h100});
    issue(3'd7, 3'd0, {14'd7, 6'd2, 12'h7FF});
    issue(3'd3, 3'd7, 32'hDEAD_BEEF);
    // R7: empty queue stall
    holdParm = 1;
    fork
      issue(3'd0, 3'd4, 32'h0);
      begin repeat (6) @(posedge clk); #2 holdParm = 0; end
    join
    issue(3'd5, 3'd3, {14'd0, 6'd5, 12'h020});
    // R8: full send slot stalls sends only
    sendHold = 1;
    issue(3'd4, 3'd1, 32'hCAFE_0001);
    issue(3'd1, 3'd2, 32'hCAFE_0002);
    fork
      issue(3'd4, 3'd3, 32'hCAFE_0003);
      begin repeat (5) @(posedge clk); #2 sendHold = 0; end
    join

    for (int n = 0; n < 600; n++)
      issue(3'($urandom % 8), 3'($urandom % 8), $urandom);

    sendForce = 1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(head == tail, "R5 all sends delivered", 64'(head), 64'(tail));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule